// File: doc/BRIEF.md
# Shared Vector Register-File Write Port Arbiter

Two execution units of a vector core produce whole-register results and must both write them through a single register-file write port. This block merges their write requests onto that one port. A request carries a destination register number, a full vector of data and a per-element write-enable mask, so a masked instruction updates only some elements. One unit is the priority unit and the other is the secondary unit. If only one unit requests, its write goes to the port on the next cycle. If both request in the same cycle, the priority unit's write goes out at once. The secondary unit's request is held in a one-entry buffer and goes out one cycle later.

The block needs a protocol rule: neither unit requests on two cycles in a row. Units gather a whole register before they write it back, so the rule holds by nature. Under this rule the held write always finds the port free on the next cycle, and one buffer entry is enough. The block also returns a hazard-release pulse to each unit. The priority unit's pulse appears in the cycle its write reaches the port. The secondary unit's pulse always comes two cycles after its request, whether or not its write was held back. The secondary unit's timing therefore never depends on what the priority unit did.

Top module: `wport_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, the write strobe, the mask and both hazard-release pulses are low.
- R2: A priority-unit request in cycle t alone produces, in cycle t+1, a port write with the priority unit's register number, data and mask.
- R3: A secondary-unit request in cycle t with no priority request in cycle t produces, in cycle t+1, a port write with the secondary unit's register number, data and mask.
- R4: When both units request in cycle t, cycle t+1 carries the priority unit's write and cycle t+2 carries the secondary unit's write, with the register number and data it had in cycle t.
- R5: The priority unit's hazard-release pulse is high in exactly the cycles in which its write is on the port. That is cycle t+1 after a request in cycle t.
- R6: The secondary unit's hazard-release pulse is high for one cycle, in cycle t+2 after a request in cycle t, with or without a collision. It is low at all other times.
- R7: Each accepted request appears on the port exactly once. The write strobe is low in any cycle that has no pending write.
- R8: Neither unit raises its request on two consecutive cycles. This is a protocol rule on the environment.
- R9: The element write-enable mask on the port equals the mask of the request being written, including partial masks on a delayed secondary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_req | input | 1 | Priority unit write request |
| pri_reg | input | AW | Priority unit destination register |
| pri_data | input | VLEN | Priority unit full-register data |
| pri_mask | input | NELEM | Priority unit element write enables |
| sec_req | input | 1 | Secondary unit write request |
| sec_reg | input | AW | Secondary unit destination register |
| sec_data | input | VLEN | Secondary unit full-register data |
| sec_mask | input | NELEM | Secondary unit element write enables |
| wr_en | output | 1 | Register-file write strobe |
| wr_reg | output | AW | Register-file write address |
| wr_data | output | VLEN | Register-file write data |
| wr_mask | output | NELEM | Register-file element write enables |
| pri_clear | output | 1 | Hazard release for the priority unit |
| sec_clear | output | 1 | Hazard release for the secondary unit |

## Verification
The bench covers every legal run of three cycles with requests from neither unit, either unit or both, each run followed by idle cycles. It also runs long alternating streams. The single-unit runs separate the direct path of each unit. The same-cycle runs show whether the secondary write is delayed by exactly one cycle and still carries its own register, data and mask. A run where the priority unit requests in cycle t and the secondary unit in cycle t+1 shows that back-to-back port writes without a collision are not delayed. Comparing the secondary release pulse across collided and clean requests shows that it lags by the same amount in both cases.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_HELD = 2'd2,
    SRC_SEC  = 2'd3
  } wpa_src_e;
endpackage

// File: rtl/wpa_hold_buf.sv
module wpa_hold_buf #(
  parameter int AW = 5,
  parameter int DW = 128,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] in_reg,
  input  logic [DW-1:0] in_data,
  input  logic [MW-1:0] in_mask,
  output logic          held_vld,
  output logic [AW-1:0] held_reg,
  output logic [DW-1:0] held_data,
  output logic [MW-1:0] held_mask
);
  // One entry is enough: the entry always drains on the cycle after it is loaded.
  always_ff @(posedge clk) begin
    if (rst) held_vld <= 1'b0;
    else     held_vld <= load;
  end

  // Payload has no reset, so it maps onto plain register banks.
  always_ff @(posedge clk) begin
    if (load) begin
      held_reg  <= in_reg;
      held_data <= in_data;
      held_mask <= in_mask;
    end
  end
endmodule

// File: rtl/wpa_select.sv
module wpa_select
  import wpa_pkg::*;
(
  input  logic     pri_req,
  input  logic     held_vld,
  input  logic     sec_req,
  output wpa_src_e src,
  output logic     collide
);
  always_comb begin
    if (pri_req)       src = SRC_PRI;
    else if (held_vld) src = SRC_HELD;
    else if (sec_req)  src = SRC_SEC;
    else               src = SRC_NONE;
  end

  assign collide = pri_req & sec_req;
endmodule

// File: rtl/wpa_release.sv
module wpa_release #(
  parameter int SEC_LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pri_req,
  input  logic sec_req,
  output logic pri_clear,
  output logic sec_clear
);
  logic [SEC_LAG-1:0] sec_pipe;

  always_ff @(posedge clk) begin
    if (rst) pri_clear <= 1'b0;
    else     pri_clear <= pri_req;
  end

  // Fixed lag for the secondary unit, independent of collisions.
  genvar g;
  generate
    for (g = 0; g < SEC_LAG; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sec_pipe[g] <= 1'b0;
          else     sec_pipe[g] <= sec_req;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sec_pipe[g] <= 1'b0;
          else     sec_pipe[g] <= sec_pipe[g-1];
        end
      end
    end
  endgenerate

  assign sec_clear = sec_pipe[SEC_LAG-1];
endmodule

// File: rtl/wport_arbiter.sv
module wport_arbiter
  import wpa_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 128,
  parameter int ELEM_W   = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int NELEM   = VLEN / ELEM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pri_req,
  input  logic [AW-1:0]    pri_reg,
  input  logic [VLEN-1:0]  pri_data,
  input  logic [NELEM-1:0] pri_mask,
  input  logic             sec_req,
  input  logic [AW-1:0]    sec_reg,
  input  logic [VLEN-1:0]  sec_data,
  input  logic [NELEM-1:0] sec_mask,
  output logic             wr_en,
  output logic [AW-1:0]    wr_reg,
  output logic [VLEN-1:0]  wr_data,
  output logic [NELEM-1:0] wr_mask,
  output logic             pri_clear,
  output logic             sec_clear
);
  logic             held_vld;
  logic [AW-1:0]    held_reg;
  logic [VLEN-1:0]  held_data;
  logic [NELEM-1:0] held_mask;
  wpa_src_e         src;
  logic             collide;

  wpa_select u_sel (
    .pri_req  (pri_req),
    .held_vld (held_vld),
    .sec_req  (sec_req),
    .src      (src),
    .collide  (collide)
  );

  wpa_hold_buf #(.AW(AW), .DW(VLEN), .MW(NELEM)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (collide),
    .in_reg    (sec_reg),
    .in_data   (sec_data),
    .in_mask   (sec_mask),
    .held_vld  (held_vld),
    .held_reg  (held_reg),
    .held_data (held_data),
    .held_mask (held_mask)
  );

  wpa_release #(.SEC_LAG(2)) u_rel (
    .clk       (clk),
    .rst       (rst),
    .pri_req   (pri_req),
    .sec_req   (sec_req),
    .pri_clear (pri_clear),
    .sec_clear (sec_clear)
  );

  // Registered port outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_mask <= '0;
    end else begin
      wr_en <= (src != SRC_NONE);
      unique case (src)
        SRC_PRI:  wr_mask <= pri_mask;
        SRC_HELD: wr_mask <= held_mask;
        SRC_SEC:  wr_mask <= sec_mask;
        default:  wr_mask <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (src)
      SRC_PRI:  begin wr_reg <= pri_reg;  wr_data <= pri_data;  end
      SRC_HELD: begin wr_reg <= held_reg; wr_data <= held_data; end
      SRC_SEC:  begin wr_reg <= sec_reg;  wr_data <= sec_data;  end
      default:  begin wr_reg <= wr_reg;   wr_data <= wr_data;   end
    endcase
  end
endmodule

// File: rtl/wport_arbiter_chk.sv
module wport_arbiter_chk #(
  parameter int AW    = 5,
  parameter int VLEN  = 128,
  parameter int NELEM = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pri_req,
  input logic [AW-1:0]    pri_reg,
  input logic [VLEN-1:0]  pri_data,
  input logic [NELEM-1:0] pri_mask,
  input logic             sec_req,
  input logic [AW-1:0]    sec_reg,
  input logic [VLEN-1:0]  sec_data,
  input logic [NELEM-1:0] sec_mask,
  input logic             wr_en,
  input logic [AW-1:0]    wr_reg,
  input logic [VLEN-1:0]  wr_data,
  input logic [NELEM-1:0] wr_mask,
  input logic             pri_clear,
  input logic             sec_clear
);
  AST_PRI_NO_B2B: assert property (@(posedge clk) disable iff (rst)
    pri_req |=> !pri_req); // R8
  AST_SEC_NO_B2B: assert property (@(posedge clk) disable iff (rst)
    sec_req |=> !sec_req); // R8
  AST_PRI_WRITE: assert property (@(posedge clk) disable iff (rst)
    pri_req |=> (wr_en && wr_reg == $past(pri_reg) && wr_data == $past(pri_data)
                 && wr_mask == $past(pri_mask))); // R2
  AST_SEC_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (sec_req && !pri_req) |=> (wr_en && wr_reg == $past(sec_reg)
                               && wr_data == $past(sec_data))); // R3
  AST_SEC_DELAYED: assert property (@(posedge clk) disable iff (rst)
    (sec_req && pri_req) |=> ##1 (wr_en && wr_reg == $past(sec_reg, 2)
                                  && wr_data == $past(sec_data, 2)
                                  && wr_mask == $past(sec_mask, 2))); // R4
  AST_PRI_CLEAR_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    pri_clear |-> wr_en); // R5
  AST_SEC_CLEAR_LAG: assert property (@(posedge clk) disable iff (rst)
    sec_req |=> ##1 sec_clear); // R6
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(pri_req) || $past(sec_req) || $past(sec_clear) == 1'b0 && sec_clear)); // R7
endmodule

bind wport_arbiter wport_arbiter_chk #(.AW(AW), .VLEN(VLEN), .NELEM(NELEM)) u_chk (
  .clk(clk), .rst(rst),
  .pri_req(pri_req), .pri_reg(pri_reg), .pri_data(pri_data), .pri_mask(pri_mask),
  .sec_req(sec_req), .sec_reg(sec_reg), .sec_data(sec_data), .sec_mask(sec_mask),
  .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data), .wr_mask(wr_mask),
  .pri_clear(pri_clear), .sec_clear(sec_clear)
);

// File: tb/wport_arbiter_tb_top.sv
module wport_arbiter_tb_top;
  localparam int NUM_REGS = 32;
  localparam int VLEN     = 128;
  localparam int ELEM_W   = 8;
  localparam int AW       = $clog2(NUM_REGS);
  localparam int NELEM    = VLEN / ELEM_W;
  localparam int DEPTH    = 2048;

  logic             clk = 1'b0;
  logic             rst;
  logic             pri_req, sec_req;
  logic [AW-1:0]    pri_reg, sec_reg;
  logic [VLEN-1:0]  pri_data, sec_data;
  logic [NELEM-1:0] pri_mask, sec_mask;
  logic             wr_en, pri_clear, sec_clear;
  logic [AW-1:0]    wr_reg;
  logic [VLEN-1:0]  wr_data;
  logic [NELEM-1:0] wr_mask;

  always #2.5 clk = ~clk;

  wport_arbiter #(.NUM_REGS(NUM_REGS), .VLEN(VLEN), .ELEM_W(ELEM_W)) dut_i (
    .clk(clk), .rst(rst),
    .pri_req(pri_req), .pri_reg(pri_reg), .pri_data(pri_data), .pri_mask(pri_mask),
    .sec_req(sec_req), .sec_reg(sec_reg), .sec_data(sec_data), .sec_mask(sec_mask),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data), .wr_mask(wr_mask),
    .pri_clear(pri_clear), .sec_clear(sec_clear)
  );

  int checks = 0, failures = 0, cyc = 0, n_exp = 0, n_seen = 0;
  // Expected source per cycle: 0 none, 1 priority, 2 secondary direct, 3 secondary delayed
  int               exp_src [DEPTH];
  logic [AW-1:0]    exp_reg [DEPTH];
  logic [VLEN-1:0]  exp_data[DEPTH];
  logic [NELEM-1:0] exp_mask[DEPTH];
  logic             exp_pclr[DEPTH];
  logic             exp_sclr[DEPTH];

  function automatic logic [VLEN-1:0] mk_data(input logic [31:0] s);
    return {s, s ^ 32'hA5A5_5A5A, ~s, s + 32'h1111_0001};
  endfunction

  task automatic chk(input string tag, input string what, input logic [VLEN-1:0] got,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", tag, what, cyc, got, exp);
    end
  endtask

  task automatic check_cycle();
    string tag;
    int s;
    s = exp_src[cyc];
    tag = (s == 1) ? "R2" : (s == 2) ? "R3" : (s == 3) ? "R4" : "R7";
    chk(tag, "wr_en", VLEN'(wr_en), VLEN'(s != 0));
    if (wr_en) n_seen++;
    if (s != 0 && wr_en) begin
      chk(tag, "wr_reg", VLEN'(wr_reg), VLEN'(exp_reg[cyc]));
      chk(tag, "wr_data", wr_data, exp_data[cyc]);
      chk("R9", "wr_mask", VLEN'(wr_mask), VLEN'(exp_mask[cyc]));
    end
    chk("R5", "pri_clear", VLEN'(pri_clear), VLEN'(exp_pclr[cyc]));
    chk("R6", "sec_clear", VLEN'(sec_clear), VLEN'(exp_sclr[cyc]));
  endtask

  // One cycle: check what the last edge produced, then drive this cycle's requests.
  // R8: callers only pass legal sequences (no unit requests twice in a row).
  task automatic step(input logic h, input logic l);
    int t;
    @(posedge clk);
    cyc++;
    #1;
    check_cycle();
    pri_req  = h;
    sec_req  = l;
    pri_reg  = AW'(cyc);
    sec_reg  = ~AW'(cyc);
    pri_data = mk_data(32'(cyc) * 32'h9E37_79B9);
    sec_data = mk_data(32'(cyc) * 32'h7F4A_7C15 + 32'h3);
    pri_mask = NELEM'(cyc * 37 + 5);
    sec_mask = NELEM'(cyc * 91 + 3);
    if (h) begin
      exp_src[cyc+1]  = 1;
      exp_reg[cyc+1]  = pri_reg;
      exp_data[cyc+1] = pri_data;
      exp_mask[cyc+1] = pri_mask;
      exp_pclr[cyc+1] = 1'b1;
      n_exp++;
    end
    if (l) begin
      t = h ? cyc + 2 : cyc + 1;
      exp_src[t]  = h ? 3 : 2;
      exp_reg[t]  = sec_reg;
      exp_data[t] = sec_data;
      exp_mask[t] = sec_mask;
      exp_sclr[cyc+2] = 1'b1;
      n_exp++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      exp_src[i] = 0; exp_reg[i] = '0; exp_data[i] = '0; exp_mask[i] = '0;
      exp_pclr[i] = 1'b0; exp_sclr[i] = 1'b0;
    end
    rst = 1'b1; pri_req = 1'b0; sec_req = 1'b0;
    pri_reg = '0; sec_reg = '0; pri_data = '0; sec_data = '0; pri_mask = '0; sec_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "wr_en", VLEN'(wr_en), '0);
    chk("R1", "wr_mask", VLEN'(wr_mask), '0);
    chk("R1", "pri_clear", VLEN'(pri_clear), '0);
    chk("R1", "sec_clear", VLEN'(sec_clear), '0);
    rst = 1'b0;
    // Near-exhaustive sweep over legal three-cycle request patterns (bit0 pri, bit1 sec).
    for (int p0 = 0; p0 < 4; p0++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++) begin
          if ((p0 & p1) == 0 && (p1 & p2) == 0) begin
            step(p0[0], p0[1]);
            step(p1[0], p1[1]);
            step(p2[0], p2[1]);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
          end
        end
    // Long streams: repeated collisions, then strict alternation between units.
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
    end
    for (int k = 0; k < 20; k++) step(k[0] == 1'b0, k[0] == 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R7: every accepted request written exactly once
    chk("R7", "write count", VLEN'(n_seen), VLEN'(n_exp));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule